// File: doc/BRIEF.md
# Interpolated Sine Oscillator

This block is a numerically controlled oscillator that produces a signed 16-bit sine wave. It keeps a 24-bit phase register made of a 16-bit integer table position above an 8-bit fraction. On every sample-enable pulse a 16-bit frequency step is added into that register. The integer position is used to fetch two neighbouring samples from an external half-cycle table of 512 signed 16-bit words. Each fetched word is negated when the position falls in the second half of the cycle, and the two words are then blended using the fraction.

The table sits outside the block as an asynchronous read memory with two read ports. The block drives both read addresses straight from its phase register and takes both data words back in the same cycle. One clock after the pulse, a registered sample appears together with a one-cycle valid strobe. The frequency step is only sampled on a pulse. All other cycles leave the phase and the output unchanged.

Top module: `sine_nco`

## Requirements
- R1: While reset is active, wave_vld is 0, wave_out is 0, and the phase register is zero, so tbl_addr_a reads 0 and tbl_addr_b reads 1.
- R2: On every clock edge where samp_en is 1, freq_inc is zero-extended and added to the 24-bit phase, with the result wrapping modulo 2^24. The phase is laid out as integer position in bits 23:8 and fraction in bits 7:0. After the edge, tbl_addr_a equals phase bits 16:8.
- R3: On edges where samp_en is 0, the phase holds whatever freq_inc carries, so both table addresses stay unchanged. wave_vld is 0 one cycle later, and wave_out keeps its value.
- R4: tbl_addr_b always equals the low 9 bits of (integer position + 1) taken modulo 2^16, so position 0xFFFF pairs with position 0.
- R5: The word for the first tap is negated (16-bit two's complement) when bit 9 of the integer position is 1. The word for the second tap is negated when bit 9 of (integer position + 1) is 1. The two decisions are made independently. Integer bits 15:10 affect neither address nor sign.
- R6: With fraction f, first tap value A and second tap value B (after the sign rule), the sample is floor((A*(255-f) + B*f) / 256), truncated to 16 bits.
- R7: A samp_en pulse sampled at edge k makes wave_vld 1 and updates wave_out at edge k+1. Both are computed from the phase as it stands after edge k. wave_vld is high for exactly one cycle per pulse, and back-to-back pulses give back-to-back samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| samp_en | input | 1 | Sample pulse: advance the phase and produce one sample |
| freq_inc | input | 16 | Phase step added per pulse |
| tbl_addr_a | output | 9 | Table read address, first tap |
| tbl_addr_b | output | 9 | Table read address, second tap |
| tbl_data_a | input | 16 | Table word returned for tbl_addr_a (same cycle) |
| tbl_data_b | input | 16 | Table word returned for tbl_addr_b (same cycle) |
| wave_out | output | 16 | Signed interpolated sample |
| wave_vld | output | 1 | One-cycle strobe marking a new wave_out |

## Verification
The hardest states to reach from the ports are the ones where the two taps straddle a boundary. One is the step from position 0x01FF to 0x0200, where only the second tap is negated. The other is the wrap from 0xFFFF to 0x0000, where only the first tap is negated. The phase advances at most 0xFFFF per pulse, so the bench steers it there with a chain of maximum-size steps followed by one exact step. Every step along the way is checked, and only then does the stimulus switch to seeded random steps with random idle gaps and a burst of back-to-back pulses.

// File: rtl/sine_nco_pkg.sv
package sine_nco_pkg;
  localparam int FRAC_W  = 8;   // fractional phase bits
  localparam int POS_W   = 16;  // integer phase bits
  localparam int TBL_AW  = 9;   // half-cycle table address width
  localparam int SMP_W   = 16;  // sample width
  localparam int INC_W   = 16;  // frequency step width
  localparam int NTAPS   = 2;   // interpolation taps
endpackage

// File: rtl/sine_nco_rst_sync.sv
module sine_nco_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/sine_nco_phase.sv
module sine_nco_phase #(
  parameter int POS_W  = 16,
  parameter int FRAC_W = 8,
  parameter int INC_W  = 16,
  localparam int PH_W  = POS_W + FRAC_W
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             step_en,
  input  logic [INC_W-1:0] step,
  output logic [PH_W-1:0]  phase
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;

  always_comb begin
    phase_d = phase_q;
    if (step_en) begin
      phase_d = phase_q + PH_W'(step);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/sine_nco_tap.sv
module sine_nco_tap #(
  parameter int POS_W  = 16,
  parameter int TBL_AW = 9,
  parameter int SMP_W  = 16,
  parameter int OFS    = 0
) (
  input  logic [POS_W-1:0]        pos,
  output logic [TBL_AW-1:0]       tbl_addr,
  input  logic [SMP_W-1:0]        tbl_word,
  output logic signed [SMP_W-1:0] smp
);
  logic [POS_W-1:0]        idx;
  logic                    flip;
  logic signed [SMP_W-1:0] raw;

  always_comb begin
    idx      = pos + POS_W'(OFS);
    tbl_addr = TBL_AW'(idx);
    flip     = 1'(idx >> TBL_AW);
    raw      = tbl_word;
    smp      = flip ? -raw : raw;
  end
endmodule

// File: rtl/sine_nco_interp.sv
module sine_nco_interp #(
  parameter int SMP_W  = 16,
  parameter int FRAC_W = 8,
  localparam int SUM_W = SMP_W + FRAC_W + 2
) (
  input  logic signed [SMP_W-1:0] smp_a,
  input  logic signed [SMP_W-1:0] smp_b,
  input  logic [FRAC_W-1:0]       frac,
  output logic signed [SMP_W-1:0] blend
);
  logic signed [FRAC_W:0] wt_a;
  logic signed [FRAC_W:0] wt_b;
  logic signed [SUM_W-1:0] acc;

  always_comb begin
    wt_a  = {1'b0, ~frac};
    wt_b  = {1'b0, frac};
    acc   = SUM_W'(smp_a) * SUM_W'(wt_a) + SUM_W'(smp_b) * SUM_W'(wt_b);
    blend = SMP_W'(acc >>> FRAC_W);
  end
endmodule

// File: rtl/sine_nco.sv
module sine_nco
  import sine_nco_pkg::*;
#(
  parameter int P_POS_W  = POS_W,
  parameter int P_FRAC_W = FRAC_W,
  parameter int P_TBL_AW = TBL_AW,
  parameter int P_SMP_W  = SMP_W,
  parameter int P_INC_W  = INC_W,
  localparam int PH_W    = P_POS_W + P_FRAC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  samp_en,
  input  logic [P_INC_W-1:0]    freq_inc,
  output logic [P_TBL_AW-1:0]   tbl_addr_a,
  output logic [P_TBL_AW-1:0]   tbl_addr_b,
  input  logic [P_SMP_W-1:0]    tbl_data_a,
  input  logic [P_SMP_W-1:0]    tbl_data_b,
  output logic [P_SMP_W-1:0]    wave_out,
  output logic                  wave_vld
);
  logic                        srst_n;
  logic [PH_W-1:0]             phase;
  logic [P_TBL_AW-1:0]         tap_addr [NTAPS];
  logic [P_SMP_W-1:0]          tap_word [NTAPS];
  logic signed [P_SMP_W-1:0]   tap_smp  [NTAPS];
  logic signed [P_SMP_W-1:0]   blend;

  logic                        pend_q, pend_d;
  logic [P_SMP_W-1:0]          out_q, out_d;
  logic                        vld_q, vld_d;

  sine_nco_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  sine_nco_phase #(
    .POS_W  (P_POS_W),
    .FRAC_W (P_FRAC_W),
    .INC_W  (P_INC_W)
  ) u_phase (
    .clk     (clk),
    .srst_n  (srst_n),
    .step_en (samp_en),
    .step    (freq_inc),
    .phase   (phase)
  );

  assign tap_word[0] = tbl_data_a;
  assign tap_word[1] = tbl_data_b;

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    sine_nco_tap #(
      .POS_W  (P_POS_W),
      .TBL_AW (P_TBL_AW),
      .SMP_W  (P_SMP_W),
      .OFS    (t)
    ) u_tap (
      .pos      (phase[PH_W-1:P_FRAC_W]),
      .tbl_addr (tap_addr[t]),
      .tbl_word (tap_word[t]),
      .smp      (tap_smp[t])
    );
  end

  assign tbl_addr_a = tap_addr[0];
  assign tbl_addr_b = tap_addr[1];

  sine_nco_interp #(
    .SMP_W  (P_SMP_W),
    .FRAC_W (P_FRAC_W)
  ) u_interp (
    .smp_a (tap_smp[0]),
    .smp_b (tap_smp[1]),
    .frac  (phase[P_FRAC_W-1:0]),
    .blend (blend)
  );

  always_comb begin
    pend_d = samp_en;
    vld_d  = pend_q;
    out_d  = out_q;
    if (pend_q) begin
      out_d = blend;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      out_q  <= '0;
    end else begin
      pend_q <= pend_d;
      vld_q  <= vld_d;
      out_q  <= out_d;
    end
  end

  assign wave_out = out_q;
  assign wave_vld = vld_q;
endmodule

// File: rtl/sine_nco_chk.sv
module sine_nco_chk #(
  parameter int AW = 9,
  parameter int SW = 16,
  parameter int IW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          samp_en,
  input logic [IW-1:0] freq_inc,
  input logic [AW-1:0] tbl_addr_a,
  input logic [AW-1:0] tbl_addr_b,
  input logic [SW-1:0] wave_out,
  input logic          wave_vld
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!wave_vld && wave_out == '0));

  assert_zero_step_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_en && freq_inc == '0) |=> ($stable(tbl_addr_a) && $stable(tbl_addr_b)));

  assert_idle_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |=> $stable(tbl_addr_a));

  assert_idle_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |=> ##1 !wave_vld);

  assert_idle_out_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |=> ##1 $stable(wave_out));

  assert_neighbour_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_addr_b == tbl_addr_a + AW'(1));

  assert_strobe_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en |=> ##1 wave_vld);
endmodule

bind sine_nco sine_nco_chk #(
  .AW (P_TBL_AW),
  .SW (P_SMP_W),
  .IW (P_INC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .samp_en    (samp_en),
  .freq_inc   (freq_inc),
  .tbl_addr_a (tbl_addr_a),
  .tbl_addr_b (tbl_addr_b),
  .wave_out   (wave_out),
  .wave_vld   (wave_vld)
);

// File: tb/sine_nco_test.sv
module sine_nco_test;
  localparam int CLK_PERIOD = 10;
  localparam real PI = 3.14159265358979;

  logic        clk;
  logic        rst_n;
  logic        samp_en;
  logic [15:0] freq_inc;
  logic [8:0]  tbl_addr_a, tbl_addr_b;
  logic [15:0] tbl_data_a, tbl_data_b;
  logic [15:0] wave_out;
  logic        wave_vld;

  logic signed [15:0] rom [0:511];
  logic [23:0] mphase;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  sine_nco uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_en    (samp_en),
    .freq_inc   (freq_inc),
    .tbl_addr_a (tbl_addr_a),
    .tbl_addr_b (tbl_addr_b),
    .tbl_data_a (tbl_data_a),
    .tbl_data_b (tbl_data_b),
    .wave_out   (wave_out),
    .wave_vld   (wave_vld)
  );

  assign tbl_data_a = rom[tbl_addr_a];
  assign tbl_data_b = rom[tbl_addr_b];

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic logic [15:0] exp_wave(input logic [23:0] ph);
    logic [15:0] ia, ib;
    int sa, sb, f, acc;
    ia = ph[23:8];
    ib = ia + 16'd1;
    f  = int'(ph[7:0]);
    sa = int'(rom[ia[8:0]]);
    sb = int'(rom[ib[8:0]]);
    if (ia[9]) sa = -sa;
    if (ib[9]) sb = -sb;
    acc = sa * (255 - f) + sb * f;
    return 16'(acc >>> 8);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_pulse(input logic [15:0] inc, input string otag);
    logic [15:0] nxt;
    @(negedge clk);
    freq_inc = inc;
    samp_en  = 1'b1;
    mphase   = mphase + 24'(inc);
    @(negedge clk);
    samp_en  = 1'b0;
    freq_inc = 16'($urandom);
    nxt = mphase[23:8] + 16'd1;
    chk("R2 addr_a", 32'(tbl_addr_a), 32'(mphase[16:8]));
    chk("R4 addr_b", 32'(tbl_addr_b), 32'(nxt[8:0]));
    chk("R7 strobe not early", 32'(wave_vld), 32'd0);
    @(negedge clk);
    chk("R7 strobe", 32'(wave_vld), 32'd1);
    chk(otag, 32'(wave_out), 32'(exp_wave(mphase)));
    @(negedge clk);
    chk("R3 strobe low", 32'(wave_vld), 32'd0);
    chk("R3 out held", 32'(wave_out), 32'(exp_wave(mphase)));
    chk("R3 phase held", 32'(tbl_addr_a), 32'(mphase[16:8]));
  endtask

  task automatic go_to(input logic [23:0] target, input string otag);
    logic [23:0] diff;
    diff = target - mphase;
    while (diff != 24'd0) begin
      do_pulse((diff > 24'h00FFFF) ? 16'hFFFF : diff[15:0], otag);
      diff = target - mphase;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] ex [0:5];
    void'($urandom(32'd4242));
    for (int i = 0; i < 512; i++) begin
      rom[i] = 16'($rtoi(32767.0 * $sin(PI * i / 512.0) + 0.5));
    end
    rst_n    = 1'b0;
    samp_en  = 1'b0;
    freq_inc = 16'h0;
    mphase   = 24'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 strobe", 32'(wave_vld), 32'd0);
    chk("R1 out", 32'(wave_out), 32'd0);
    chk("R1 addr_a", 32'(tbl_addr_a), 32'd0);
    chk("R1 addr_b", 32'(tbl_addr_b), 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: step input ignored while idle
    for (int i = 0; i < 6; i++) begin
      freq_inc = 16'($urandom);
      @(negedge clk);
      chk("R3 idle addr", 32'(tbl_addr_a), 32'd0);
      chk("R3 idle strobe", 32'(wave_vld), 32'd0);
    end

    // R2: zero step keeps phase; then small fractional steps
    do_pulse(16'h0000, "R6 zero step");
    do_pulse(16'h0080, "R6 half fraction");
    do_pulse(16'h0080, "R6 fraction zero");

    // R5: walk up to the half-cycle sign boundary
    go_to(24'h01FF40, "R6 approach");
    do_pulse(16'h0040, "R5 second tap negated");
    do_pulse(16'h00C0, "R5 both negated");
    do_pulse(16'h0001, "R5 fraction one");

    // R2/R4/R5: wrap of the integer position and of the full phase
    go_to(24'hFFFF00, "R2 long walk");
    do_pulse(16'h00A0, "R5 wrap first tap negated");
    do_pulse(16'h0060, "R2 full wrap to zero");
    chk("R2 wrapped phase", 32'(tbl_addr_a), 32'd0);

    // R6: seeded random steps with random idle gaps
    for (int n = 0; n < 300; n++) begin
      do_pulse(16'($urandom), "R6 random");
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    // R7: back-to-back pulses
    for (int j = 0; j < 6; j++) begin
      logic [15:0] inc;
      @(negedge clk);
      if (j >= 2) begin
        chk("R7 burst strobe", 32'(wave_vld), 32'd1);
        chk("R7 burst out", 32'(wave_out), 32'(ex[j-2]));
      end
      if (j < 4) begin
        inc      = 16'($urandom);
        freq_inc = inc;
        samp_en  = 1'b1;
        mphase   = mphase + 24'(inc);
        ex[j]    = exp_wave(mphase);
      end else begin
        samp_en = 1'b0;
      end
    end
    @(negedge clk);
    chk("R7 burst end", 32'(wave_vld), 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule